// File: doc/BRIEF.md
# Lockable Cipher Key Register Bank

This block stores the key material and per-context settings that a memory cipher core consumes, behind a plain single-cycle write / registered-read bus. It holds two global key sets of four 32-bit words each (a master set and a fast master set) and a parameterised number of cipher contexts. Each context carries a 64-bit nonce, a four-word key and a configuration word with an enable bit, two lock bits, a version field and a read-only key-CRC field fed from an external port.

Protection comes from sticky lock bits at three levels: a global lock, a lock covering both global key sets, and per-context configuration and key locks. A write stopped by a lock changes nothing, raises a dropped-write flag and, when enabled, an interrupt line. Each key set reports a valid flag once a complete key has been loaded in word order. Key words never read back over the bus. Locks are released only by reset.

Top module: `keybank`

## Requirements
- R1: After reset every key, nonce, configuration field, lock, valid flag, the dropped-write flag and `irq` are zero; reads of CTRL (0x000) and STATUS (0x004) return 0.
- R2: Writing 1 to CTRL bit 0 sets the global lock; from then on every write is dropped except writes to IRQ_EN (0x008) and IRQ_CLR (0x00C), which keep working.
- R3: Writing 1 to CTRL bit 1 sets the key-set lock; writes to the master words (0x010..0x01C) and fast master words (0x020..0x02C) are then dropped and the stored keys and their valid flags hold.
- R4: Every lock bit (CTRL bits 0 and 1, context config bits 1 and 2) can only go from 0 to 1; writing 0 leaves it set until reset.
- R5: A key set's valid flag (STATUS bit 0 master, bit 1 fast master, bit 4+i context i) becomes 1 after its words 0, 1, 2, 3 (offsets +0, +4, +8, +C) are written in that order; word i appears on the key output port at bits [32*i +: 32].
- R6: Any accepted write to a word of a key set clears its valid flag unless that write completes an in-order 0..3 sequence; an out-of-order sequence leaves the flag at 0.
- R7: Context config word bit 1 is the config lock; once set, writes to that context's config word (offset +0x00) and nonce words (+0x04, +0x08) are dropped, so enable (bit 0), version (bits 7:4) and the nonce hold.
- R8: Context config word bit 2 is the key lock; once set, writes to that context's key words (+0x10..+0x1C) are dropped and the key-CRC field (bits 15:8), which otherwise tracks `ctx_crc_in` one cycle later, holds its value.
- R9: A read returns data on `bus_rdata` with `bus_rvalid` one cycle after `bus_rd`; key word addresses, IRQ_CLR and unmapped or unaligned addresses read as 0.
- R10: A dropped write sets STATUS bit 2; writing 1 to IRQ_CLR bit 0 clears it; `irq` is the registered AND of that flag and IRQ_EN bit 0.
- R11: Context i occupies addresses 0x240 + 0x30*i; its enable, version, nonce and key drive the context output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ctx_crc_in | input | NCTX*CRC_W | Key CRC per context from the CRC unit |
| mkey_words | output | 4*WORD_W | Master key words |
| fmkey_words | output | 4*WORD_W | Fast master key words |
| mkey_valid | output | 1 | Master key set complete |
| fmkey_valid | output | 1 | Fast master key set complete |
| ctx_key | output | NCTX*4*WORD_W | Context keys |
| ctx_key_valid | output | NCTX | Context key sets complete |
| ctx_nonce | output | NCTX*2*WORD_W | Context nonces |
| ctx_enable | output | NCTX | Context enable bits |
| ctx_version | output | NCTX*VER_W | Context version fields |
| irq | output | 1 | Dropped-write interrupt |

## Verification
The bench loads key sets in order and out of order, then rewrites a single word of a complete set, because a tracker that only watched word 3, or never cleared on a middle word, would report a half-replaced key as valid. It writes 0 to every lock after setting it, which catches a lock stored as a plain read-write bit. It moves `ctx_crc_in` after the key lock, so a design that kept sampling the CRC would show the new value. Under the global lock it confirms IRQ_EN and IRQ_CLR still respond while CTRL, context and key writes do not, which catches both an over-broad and an incomplete global gate.

// File: rtl/keybank_pkg.sv
package keybank_pkg;

  // Register map, byte addresses
  localparam int A_CTRL    = 'h000;
  localparam int A_STATUS  = 'h004;
  localparam int A_IRQ_EN  = 'h008;
  localparam int A_IRQ_CLR = 'h00C;
  localparam int A_MK_LO   = 'h010;
  localparam int A_FMK_LO  = 'h020;
  localparam int KSET_SPAN = 'h010;

  // Context window
  localparam int CTX_BASE   = 'h240;
  localparam int CTX_STRIDE = 'h030;
  localparam int OFF_CFG    = 'h00;
  localparam int OFF_NONCE0 = 'h04;
  localparam int OFF_NONCE1 = 'h08;
  localparam int OFF_KEY_LO = 'h10;

  // Control and status bit positions
  localparam int CTRL_GLOCK  = 0;
  localparam int CTRL_KLOCK  = 1;
  localparam int ST_MK_VAL   = 0;
  localparam int ST_FMK_VAL  = 1;
  localparam int ST_DROP     = 2;
  localparam int ST_CTX_BASE = 4;

  // Context config bits
  localparam int CFG_EN     = 0;
  localparam int CFG_CLOCK  = 1;
  localparam int CFG_KLOCK  = 2;
  localparam int CFG_VER_LO = 4;
  localparam int CFG_CRC_LO = 8;

endpackage

// File: rtl/keybank_keyset.sv
module keybank_keyset #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int PW    = $clog2(NWORDS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [IDX_W-1:0]         widx,
  input  logic [WORD_W-1:0]        wdata,
  input  logic                     lock,
  output logic [NWORDS*WORD_W-1:0] words,
  output logic                     valid
);

  logic [NWORDS-1:0][WORD_W-1:0] mem;
  logic [PW-1:0]                 prog;
  logic                          take;

  assign take = wr && !lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem   <= '0;
      prog  <= '0;
      valid <= 1'b0;
    end else if (take) begin
      mem[widx] <= wdata;
      if (widx == '0) begin
        prog  <= PW'(1);
        valid <= 1'b0;
      end else if (PW'(widx) == prog) begin
        if (widx == IDX_W'(NWORDS - 1)) begin
          valid <= 1'b1;
          prog  <= '0;
        end else begin
          valid <= 1'b0;
          prog  <= prog + 1'b1;
        end
      end else begin
        valid <= 1'b0;
        prog  <= '0;
      end
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_out
    assign words[w*WORD_W +: WORD_W] = mem[w];
  end

  AST_LOCK_HOLDS_KEY: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(mem)); // R3

  AST_VALID_NEEDS_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(wr && !lock && widx == IDX_W'(NWORDS - 1))); // R5

  AST_WORD0_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr && !lock && widx == '0) |=> !valid); // R6

endmodule

// File: rtl/keybank_ctx.sv
module keybank_ctx
  import keybank_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CRC_W  = 8,
  parameter int VER_W  = 4,
  localparam int KEY_W = 4 * WORD_W,
  localparam int PAD_W = WORD_W - CFG_CRC_LO - CRC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic                nonce_wr,
  input  logic                nonce_idx,
  input  logic                key_wr,
  input  logic [1:0]          key_idx,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [CRC_W-1:0]    crc_in,
  output logic [WORD_W-1:0]   cfg_word,
  output logic [2*WORD_W-1:0] nonce,
  output logic [KEY_W-1:0]    key,
  output logic                key_valid,
  output logic                enable,
  output logic [VER_W-1:0]    version,
  output logic                cfg_locked,
  output logic                key_locked
);

  logic [1:0][WORD_W-1:0] nonce_q;
  logic [CRC_W-1:0]       crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable     <= 1'b0;
      cfg_locked <= 1'b0;
      key_locked <= 1'b0;
      version    <= '0;
      nonce_q    <= '0;
    end else if (!cfg_locked) begin
      if (cfg_wr) begin
        enable     <= wdata[CFG_EN];
        cfg_locked <= wdata[CFG_CLOCK];
        key_locked <= key_locked | wdata[CFG_KLOCK];
        version    <= wdata[CFG_VER_LO +: VER_W];
      end
      if (nonce_wr) nonce_q[nonce_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              crc_q <= '0;
    else if (!key_locked) crc_q <= crc_in;
  end

  keybank_keyset #(.WORD_W(WORD_W), .NWORDS(4)) u_key (
    .clk   (clk),
    .rst   (rst),
    .wr    (key_wr),
    .widx  (key_idx),
    .wdata (wdata),
    .lock  (key_locked),
    .words (key),
    .valid (key_valid)
  );

  assign nonce    = {nonce_q[1], nonce_q[0]};
  assign cfg_word = {{PAD_W{1'b0}}, crc_q, {(CFG_CRC_LO - CFG_VER_LO - VER_W){1'b0}},
                     version, 1'b0, key_locked, cfg_locked, enable};

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> ($stable(nonce_q) && $stable(enable) && $stable(version))); // R7

  AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    key_locked |=> $stable(crc_q)); // R8

  AST_KLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    key_locked |=> key_locked); // R4

  AST_CLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> cfg_locked); // R4

endmodule

// File: rtl/keybank.sv
module keybank
  import keybank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int NCTX   = 2,
  parameter int CRC_W  = 8,
  parameter int VER_W  = 4,
  localparam int KEY_W  = 4 * WORD_W,
  localparam int STAT_W = ST_CTX_BASE + NCTX
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NCTX*CRC_W-1:0]    ctx_crc_in,
  output logic [KEY_W-1:0]         mkey_words,
  output logic [KEY_W-1:0]         fmkey_words,
  output logic                     mkey_valid,
  output logic                     fmkey_valid,
  output logic [NCTX*KEY_W-1:0]    ctx_key,
  output logic [NCTX-1:0]          ctx_key_valid,
  output logic [NCTX*2*WORD_W-1:0] ctx_nonce,
  output logic [NCTX-1:0]          ctx_enable,
  output logic [NCTX*VER_W-1:0]    ctx_version,
  output logic                     irq
);

  // ---------------- decode ----------------
  logic aligned;
  logic sel_ctrl, sel_status, sel_irqen, sel_clr, sel_mk, sel_fmk;
  logic [1:0] kidx;

  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign sel_ctrl   = aligned && bus_addr == ADDR_W'(A_CTRL);
  assign sel_status = aligned && bus_addr == ADDR_W'(A_STATUS);
  assign sel_irqen  = aligned && bus_addr == ADDR_W'(A_IRQ_EN);
  assign sel_clr    = aligned && bus_addr == ADDR_W'(A_IRQ_CLR);
  assign sel_mk     = aligned && bus_addr >= ADDR_W'(A_MK_LO)
                              && bus_addr <  ADDR_W'(A_MK_LO + KSET_SPAN);
  assign sel_fmk    = aligned && bus_addr >= ADDR_W'(A_FMK_LO)
                              && bus_addr <  ADDR_W'(A_FMK_LO + KSET_SPAN);
  assign kidx       = bus_addr[3:2];

  // ---------------- lock state ----------------
  logic glock_q, klock_q;
  logic wr_ok;

  assign wr_ok = bus_wr && !glock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      glock_q <= 1'b0;
      klock_q <= 1'b0;
    end else if (wr_ok && sel_ctrl) begin
      glock_q <= glock_q | bus_wdata[CTRL_GLOCK];
      klock_q <= klock_q | bus_wdata[CTRL_KLOCK];
    end
  end

  // ---------------- global key sets ----------------
  keybank_keyset #(.WORD_W(WORD_W), .NWORDS(4)) u_mk (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_ok && sel_mk),
    .widx  (kidx),
    .wdata (bus_wdata),
    .lock  (klock_q),
    .words (mkey_words),
    .valid (mkey_valid)
  );

  keybank_keyset #(.WORD_W(WORD_W), .NWORDS(4)) u_fmk (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_ok && sel_fmk),
    .widx  (kidx),
    .wdata (bus_wdata),
    .lock  (klock_q),
    .words (fmkey_words),
    .valid (fmkey_valid)
  );

  // ---------------- contexts ----------------
  logic [NCTX-1:0]             sel_cfg, sel_nonce, sel_key, ctx_drop;
  logic [NCTX-1:0]             cfg_lk, key_lk;
  logic [NCTX-1:0][WORD_W-1:0] ctx_rd;

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CTX_BASE + CTX_STRIDE * i);
    logic [ADDR_W-1:0]   off;
    logic                hit;
    logic [WORD_W-1:0]   cfg_word;
    logic [2*WORD_W-1:0] nonce;

    assign off          = bus_addr - BASE;
    assign hit          = aligned && bus_addr >= BASE && off < ADDR_W'(CTX_STRIDE);
    assign sel_cfg[i]   = hit && off == ADDR_W'(OFF_CFG);
    assign sel_nonce[i] = hit && (off == ADDR_W'(OFF_NONCE0) || off == ADDR_W'(OFF_NONCE1));
    assign sel_key[i]   = hit && off >= ADDR_W'(OFF_KEY_LO)
                              && off <  ADDR_W'(OFF_KEY_LO + KSET_SPAN);

    keybank_ctx #(.WORD_W(WORD_W), .CRC_W(CRC_W), .VER_W(VER_W)) u_ctx (
      .clk        (clk),
      .rst        (rst),
      .cfg_wr     (wr_ok && sel_cfg[i]),
      .nonce_wr   (wr_ok && sel_nonce[i]),
      .nonce_idx  (off == ADDR_W'(OFF_NONCE1)),
      .key_wr     (wr_ok && sel_key[i]),
      .key_idx    (off[3:2]),
      .wdata      (bus_wdata),
      .crc_in     (ctx_crc_in[i*CRC_W +: CRC_W]),
      .cfg_word   (cfg_word),
      .nonce      (nonce),
      .key        (ctx_key[i*KEY_W +: KEY_W]),
      .key_valid  (ctx_key_valid[i]),
      .enable     (ctx_enable[i]),
      .version    (ctx_version[i*VER_W +: VER_W]),
      .cfg_locked (cfg_lk[i]),
      .key_locked (key_lk[i])
    );

    assign ctx_nonce[i*2*WORD_W +: 2*WORD_W] = nonce;
    assign ctx_drop[i] = ((sel_cfg[i] || sel_nonce[i]) && cfg_lk[i]) || (sel_key[i] && key_lk[i]);
    assign ctx_rd[i]   = sel_cfg[i] ? cfg_word :
                         (sel_nonce[i] && off == ADDR_W'(OFF_NONCE1)) ? nonce[WORD_W +: WORD_W] :
                         sel_nonce[i] ? nonce[WORD_W-1:0] : '0;
  end

  // ---------------- dropped writes and interrupt ----------------
  logic any_mapped, drop, drop_q, irq_en_q;

  assign any_mapped = sel_ctrl || sel_status || sel_mk || sel_fmk ||
                      (|sel_cfg) || (|sel_nonce) || (|sel_key);
  assign drop = bus_wr && (glock_q ? any_mapped
                                   : (((sel_mk || sel_fmk) && klock_q) || (|ctx_drop)));

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q   <= 1'b0;
      irq_en_q <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (drop)                                      drop_q <= 1'b1;
      else if (bus_wr && sel_clr && bus_wdata[0])    drop_q <= 1'b0;
      if (bus_wr && sel_irqen)                       irq_en_q <= bus_wdata[0];
      irq <= drop_q && irq_en_q;
    end
  end

  // ---------------- read path ----------------
  logic [STAT_W-1:0] status;
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    status              = '0;
    status[ST_MK_VAL]   = mkey_valid;
    status[ST_FMK_VAL]  = fmkey_valid;
    status[ST_DROP]     = drop_q;
    status[ST_CTX_BASE +: NCTX] = ctx_key_valid;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)   rd_mux = WORD_W'({klock_q, glock_q});
    if (sel_status) rd_mux = WORD_W'(status);
    if (sel_irqen)  rd_mux = WORD_W'(irq_en_q);
    for (int i = 0; i < NCTX; i++) rd_mux = rd_mux | ctx_rd[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

  AST_GLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    glock_q |=> glock_q); // R4

  AST_KLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    klock_q |=> klock_q); // R4

  AST_GLOCK_FREEZES: assert property (@(posedge clk) disable iff (rst)
    glock_q |=> ($stable(klock_q) && $stable(ctx_enable) && $stable(ctx_nonce))); // R2

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en_q && drop_q)); // R10

endmodule

// File: tb/keybank_tb.sv
module keybank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;
  localparam int NCTX   = 2;
  localparam int CRC_W  = 8;
  localparam int VER_W  = 4;
  localparam int KEY_W  = 4 * WORD_W;
  localparam int WD_CYCLES = 20000;

  localparam logic [ADDR_W-1:0] A_CTRL = 12'h000, A_STAT = 12'h004, A_IEN = 12'h008,
                                A_ICLR = 12'h00C, A_MK = 12'h010, A_FMK = 12'h020,
                                C0 = 12'h240, C1 = 12'h270;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [WORD_W-1:0] bus_wdata = '0;
  logic [WORD_W-1:0] bus_rdata;
  logic bus_rvalid;
  logic [NCTX*CRC_W-1:0] ctx_crc_in = '0;
  logic [KEY_W-1:0] mkey_words, fmkey_words;
  logic mkey_valid, fmkey_valid;
  logic [NCTX*KEY_W-1:0] ctx_key;
  logic [NCTX-1:0] ctx_key_valid, ctx_enable;
  logic [NCTX*2*WORD_W-1:0] ctx_nonce;
  logic [NCTX*VER_W-1:0] ctx_version;
  logic irq;

  int checks = 0;
  int fails  = 0;
  logic [WORD_W-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  keybank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NCTX(NCTX), .CRC_W(CRC_W), .VER_W(VER_W)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ctx_crc_in(ctx_crc_in), .mkey_words(mkey_words), .fmkey_words(fmkey_words),
    .mkey_valid(mkey_valid), .fmkey_valid(fmkey_valid), .ctx_key(ctx_key),
    .ctx_key_valid(ctx_key_valid), .ctx_nonce(ctx_nonce), .ctx_enable(ctx_enable),
    .ctx_version(ctx_version), .irq(irq)
  );

  task automatic check(input string tag, input logic [KEY_W-1:0] act, input logic [KEY_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data arrives
  always @(negedge clk) begin
    logic [WORD_W-1:0] e;
    string t;
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected read data", KEY_W'(bus_rdata), '1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, KEY_W'(bus_rdata), KEY_W'(e));
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load4(input logic [ADDR_W-1:0] base, input logic [WORD_W-1:0] seed);
    for (int w = 0; w < 4; w++) wr(base + ADDR_W'(4*w), seed + WORD_W'(w));
  endtask

  function automatic logic [KEY_W-1:0] kval(input logic [WORD_W-1:0] seed);
    return {seed + 32'd3, seed + 32'd2, seed + 32'd1, seed};
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [WORD_W-1:0] MK = 32'hA5A5_0000, FK = 32'h5A5A_1000, CK = 32'hC0DE_2000;
  localparam logic [WORD_W-1:0] N0 = 32'h1234_5678;

  initial begin
    wait_cyc(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, 0, "R1 ctrl after reset");
    rd(A_STAT, 0, "R1 status after reset");
    check("R1 irq after reset", KEY_W'(irq), 0);
    check("R1 master key after reset", mkey_words, 0);

    // R5 in-order load, R9 key read-back
    load4(A_MK, MK);
    rd(A_STAT, 32'h1, "R5 master valid");
    check("R5 master key port", mkey_words, kval(MK));
    rd(A_MK, 0, "R9 key word reads zero");
    rd(12'h002, 0, "R9 unaligned reads zero");

    // R6 out of order, then in order
    wr(A_FMK + 0, FK); wr(A_FMK + 8, FK + 2); wr(A_FMK + 4, FK + 1); wr(A_FMK + 12, FK + 3);
    rd(A_STAT, 32'h1, "R6 out-of-order stays invalid");
    load4(A_FMK, FK);
    rd(A_STAT, 32'h3, "R5 fast master valid");
    wr(A_MK + 8, 32'hDEAD);
    rd(A_STAT, 32'h2, "R6 middle word clears valid");
    load4(A_MK, MK);
    rd(A_STAT, 32'h3, "R6 reload restores valid");

    // R11 / R8 context setup
    ctx_crc_in = {8'h00, 8'h3C};
    wr(C0, 32'h51);
    wr(C0 + 4, N0);
    rd(C0, 32'h3C51, "R8 cfg with crc field");
    rd(C0 + 4, N0, "R11 ctx0 nonce read");
    check("R11 ctx0 enable port", KEY_W'(ctx_enable), 1);
    check("R11 ctx0 version port", KEY_W'(ctx_version), 5);
    load4(C1 + 12'h10, CK);
    rd(A_STAT, 32'h23, "R11 ctx1 key valid");
    check("R11 ctx1 key port", ctx_key[KEY_W +: KEY_W], kval(CK));

    // R8 key lock
    wr(C0, 32'h55);
    ctx_crc_in = {8'h00, 8'h77};
    wait_cyc(2);
    rd(C0, 32'h3C55, "R8 crc frozen after key lock");
    wr(C0 + 12'h10, 32'hBEEF);
    check("R8 locked key unchanged", ctx_key[KEY_W-1:0], 0);
    rd(A_STAT, 32'h27, "R10 drop flag set");
    check("R10 irq off while disabled", KEY_W'(irq), 0);

    // R10 interrupt
    wr(A_IEN, 1);
    wait_cyc(2);
    check("R10 irq asserted", KEY_W'(irq), 1);
    wr(A_ICLR, 1);
    wait_cyc(2);
    check("R10 irq cleared", KEY_W'(irq), 0);
    rd(A_STAT, 32'h23, "R10 flag cleared");

    // R7 config lock
    wr(C0, 32'h57);
    rd(C0, 32'h3C57, "R7 cfg lock set");
    wr(C0, 32'h00);
    rd(C0, 32'h3C57, "R7 cfg write dropped");
    check("R7 enable held", KEY_W'(ctx_enable[0]), 1);
    wr(C0 + 4, 32'hDEAD);
    rd(C0 + 4, N0, "R7 nonce write dropped");
    wr(A_ICLR, 1);

    // R3 / R4 key-set lock
    wr(A_CTRL, 2);
    rd(A_CTRL, 2, "R3 key-set lock set");
    wr(A_CTRL, 0);
    rd(A_CTRL, 2, "R4 lock not clearable");
    wr(A_MK, 32'hFFFF);
    wr(A_FMK + 4, 32'hFFFF);
    check("R3 master key held", mkey_words, kval(MK));
    check("R3 fast master key held", fmkey_words, kval(FK));
    rd(A_STAT, 32'h27, "R3 valid held and drop flagged");
    wr(A_ICLR, 1);

    // R2 global lock
    wr(A_CTRL, 1);
    rd(A_CTRL, 3, "R2 global lock set");
    wr(C1, 32'h1);
    check("R2 ctx1 enable unchanged", KEY_W'(ctx_enable[1]), 0);
    wr(C1 + 4, 32'h4444);
    rd(C1 + 4, 0, "R2 nonce write dropped");
    rd(A_STAT, 32'h27, "R2 drop flagged");
    wr(A_ICLR, 1);
    rd(A_STAT, 32'h23, "R2 clear still works");
    wr(A_CTRL, 0);
    rd(A_CTRL, 3, "R4 global lock not clearable");
    wr(A_IEN, 0);
    rd(A_IEN, 0, "R2 enable still writable");
    wait_cyc(2);
    check("R2 irq off after enable cleared", KEY_W'(irq), 0);

    wait_cyc(4);
    check("R9 scoreboard drained", KEY_W'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule